// File: doc/BRIEF.md
# Column-pass cosine transform with quantizing scaler

This block performs the second pass of an eight-point two-dimensional cosine transform and quantizes the result. First-pass row sums arrive one at a time. Each one is written into one slot of an eight-slot holding bank. A 3-bit slot index and a load strobe control the write. The bank presents all of its slots at once. This lets a single block of first-pass sums serve eight consecutive column computations, one for each row of the transposed cosine matrix.

For each issued operation the block does the following:

- It multiplies every stored slot by the matching 8-bit element of the supplied cosine row.
- It sums the eight products, keeping 14 bits.
- It keeps the low 12 bits of that sum.
- It multiplies those 12 bits by a supplied 8-bit reciprocal quantization step, in place of a divide.
- It rounds the product and emits a 9-bit quantized coefficient.

Both the cosine row and the reciprocal step are inputs, so the tables that supply them live outside this block. The external sequencer drives the load index, the load strobe and the issue strobe.

The pipeline has three registered stages: products, sum, and scaled output. An issue may be made on every clock, and a bank write may take place in the same cycle as an issue.

Top module: `colq_top`

## Requirements
- R1: While `rst_n` is low, and at the first edge after it is released, every bank slot reads as zero, `coef_valid` is 0 and `coef` is 0.
- R2: When `ld_en` is 1 on a clock edge, slot `ld_sel` takes `ld_val` (11-bit two's complement) and all other slots keep their values.
- R3: When `ld_en` is 0, no slot changes, whatever `ld_sel` and `ld_val` carry.
- R4: A slot keeps its value for any number of issues until it is written again. An issue in the same cycle as a write uses the slot values from before that write.
- R5: An issue forms S = sum over lanes i of slot[i] × cos_row[8i+7:8i], with both factors in two's complement, and keeps S modulo 2^14.
- R6: Only bits 11:0 of S are used, read as a signed 12-bit value V. V is multiplied by `iq_val`, read as unsigned 0..255. An `iq_val` of 0 gives a result of 0.
- R7: `coef` = floor((V × iq_val + 1024) / 2048), written as 9-bit two's complement. A non-negative V never gives a negative `coef`.
- R8: `coef_valid` is high exactly three clock edges after the edge that samples `go` high. Issues on consecutive cycles give results on consecutive cycles, in issue order.
- R9: `coef` does not change in any cycle that does not deliver a new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load strobe for the holding bank |
| ld_sel | input | 3 | Slot index for the load |
| ld_val | input | 11 | First-pass row sum, two's complement |
| go | input | 1 | Issue a column computation this cycle |
| cos_row | input | 64 | Eight signed 8-bit cosine elements, lane i in bits 8i+7:8i |
| iq_val | input | 8 | Unsigned reciprocal quantization step |
| coef_valid | output | 1 | A new coefficient is on `coef` |
| coef | output | 9 | Quantized coefficient, two's complement |

## Verification
The in-line properties check the following on every cycle:

- the state after reset;
- write targeting in the bank, and that slots stay put without a load strobe;
- the fixed three-edge delay from issue to valid;
- that the output holds when no result is delivered;
- the zero output for a zero reciprocal step;
- the sign of results from non-negative sums.

Only the bench's scenarios can show that the arithmetic itself is right. That covers 14-bit wrap of large sums, 12-bit truncation flipping the sign, half-LSB rounding at the ±1024 boundary, extreme slot and cosine values, and an issue that overlaps a write.

// File: rtl/colq_pkg.sv
package colq_pkg;
   // Default geometry of the column pass
   localparam int LANES_D  = 8;   // slots in the holding bank
   localparam int ENT_W_D  = 11;  // slot width
   localparam int COS_W_D  = 8;   // cosine element width
   localparam int SUM_W_D  = 14;  // kept width of the lane sum
   localparam int QIN_W_D  = 12;  // sum bits fed to the scaler
   localparam int IQ_W_D   = 8;   // reciprocal step width
   localparam int COEF_W_D = 9;   // output coefficient width
endpackage

// File: rtl/colq_bank.sv
module colq_bank
   import colq_pkg::*;
#(
   parameter int N     = LANES_D,
   parameter int ENT_W = ENT_W_D,
   parameter int SEL_W = $clog2(N)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [SEL_W-1:0]          wr_sel,
   input  logic [ENT_W-1:0]          wr_data,
   output logic [N-1:0][ENT_W-1:0]   ent
);

   if (N < 2) begin : g_bad_n
      $error("colq_bank: N must be at least 2");
   end
   if (ENT_W < 2) begin : g_bad_w
      $error("colq_bank: ENT_W must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent[i] <= '0;
         else if (wr_en && (wr_sel == SEL_W'(i)))
            ent[i] <= wr_data;
      end
   end

   // R3: without a load strobe the bank is frozen
   p_bank_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ent));

   // R2: the addressed slot takes the written value
   p_slot_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ({1'b0, wr_sel} < (SEL_W+1)'(N))) |=> ent[$past(wr_sel)] == $past(wr_data));

endmodule

// File: rtl/colq_mac.sv
module colq_mac
   import colq_pkg::*;
#(
   parameter int N     = LANES_D,
   parameter int ENT_W = ENT_W_D,
   parameter int COS_W = COS_W_D,
   parameter int SUM_W = SUM_W_D,
   parameter int IQ_W  = IQ_W_D
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_v,
   input  logic [N-1:0][ENT_W-1:0]   ent,
   input  logic [N*COS_W-1:0]        cos_row,
   input  logic [IQ_W-1:0]           iq_in,
   output logic                      sum_v,
   output logic [SUM_W-1:0]          sum,
   output logic [IQ_W-1:0]           iq_out
);

   localparam int PROD_W = ENT_W + COS_W;
   localparam int ACC_W  = PROD_W + $clog2(N);
   localparam bit POW2   = ((N & (N - 1)) == 0);

   if (SUM_W >= ACC_W) begin : g_bad_sum
      $error("colq_mac: SUM_W must be narrower than the full lane sum");
   end
   if (COS_W < 2) begin : g_bad_cos
      $error("colq_mac: COS_W must be at least 2");
   end

   // ---- stage 1: lane products ----
   logic signed [PROD_W-1:0] prod [N];
   logic                     v1;
   logic [IQ_W-1:0]          iq1;

   for (genvar i = 0; i < N; i++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            prod[i] <= '0;
         else if (in_v)
            prod[i] <= PROD_W'($signed(ent[i])) *
                       PROD_W'($signed(cos_row[i*COS_W +: COS_W]));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1  <= 1'b0;
         iq1 <= '0;
      end else begin
         v1 <= in_v;
         if (in_v)
            iq1 <= iq_in;
      end
   end

   // ---- adder tree: pairwise for power-of-two lane counts, chain otherwise ----
   logic signed [ACC_W-1:0] tree_sum;

   if (POW2) begin : g_pair_tree
      logic signed [ACC_W-1:0] node [2*N-1];
      for (genvar i = 0; i < N; i++) begin : g_leaf
         assign node[N-1+i] = ACC_W'(prod[i]);
      end
      for (genvar k = 0; k < N-1; k++) begin : g_node
         assign node[k] = node[2*k+1] + node[2*k+2];
      end
      assign tree_sum = node[0];
   end else begin : g_chain
      always_comb begin
         tree_sum = '0;
         for (int i = 0; i < N; i++)
            tree_sum = tree_sum + ACC_W'(prod[i]);
      end
   end

   // ---- stage 2: kept sum ----
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_v  <= 1'b0;
         sum    <= '0;
         iq_out <= '0;
      end else begin
         sum_v <= v1;
         if (v1) begin
            sum    <= tree_sum[SUM_W-1:0];
            iq_out <= iq1;
         end
      end
   end

   logic unused_hi;
   assign unused_hi = ^tree_sum[ACC_W-1:SUM_W];

   // R9: the kept sum moves only when a product set arrives
   p_sum_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !v1 |=> $stable(sum));

endmodule

// File: rtl/colq_quant.sv
module colq_quant
   import colq_pkg::*;
#(
   parameter int SUM_W  = SUM_W_D,
   parameter int QIN_W  = QIN_W_D,
   parameter int IQ_W   = IQ_W_D,
   parameter int OUT_W  = COEF_W_D,
   parameter bit ROUND  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_v,
   input  logic [SUM_W-1:0]  sum,
   input  logic [IQ_W-1:0]   iq,
   output logic              out_v,
   output logic [OUT_W-1:0]  coef
);

   localparam int QP_W  = QIN_W + IQ_W + 1;
   localparam int SHIFT = QIN_W - 1;

   if (SUM_W <= QIN_W) begin : g_bad_qin
      $error("colq_quant: QIN_W must be narrower than SUM_W");
   end
   if (OUT_W != IQ_W + 1) begin : g_bad_out
      $error("colq_quant: OUT_W must equal IQ_W + 1");
   end
   if (SHIFT < 1) begin : g_bad_shift
      $error("colq_quant: QIN_W must be at least 2");
   end

   logic signed [QIN_W-1:0] s_lo;
   logic signed [QP_W-1:0]  scaled;
   logic signed [QP_W-1:0]  rnd;

   assign s_lo   = sum[QIN_W-1:0];
   assign scaled = QP_W'(s_lo) * QP_W'($signed({1'b0, iq}));

   if (ROUND) begin : g_round
      localparam logic signed [QP_W-1:0] HALF = QP_W'(1) << (SHIFT - 1);
      assign rnd = scaled + HALF;
   end else begin : g_trunc
      assign rnd = scaled;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_v <= 1'b0;
         coef  <= '0;
      end else begin
         out_v <= in_v;
         if (in_v)
            coef <= rnd[SHIFT +: OUT_W];
      end
   end

   logic unused_q;
   assign unused_q = ^{sum[SUM_W-1:QIN_W], rnd[QP_W-1], rnd[SHIFT-1:0]};

   // R1: reset clears the output
   p_reset_out_r1: assert property (@(posedge clk)
      !rst_n |=> (!out_v && (coef == '0)));

   // R9: no delivery, no change
   p_coef_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_v |=> $stable(coef));

   // R6: a zero reciprocal step forces a zero coefficient
   p_zero_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_v && (iq == '0)) |=> (coef == '0));

   // R7: non-negative truncated sum never yields a negative coefficient
   p_sign_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_v && !s_lo[QIN_W-1]) |=> !coef[OUT_W-1]);

endmodule

// File: rtl/colq_top.sv
module colq_top
   import colq_pkg::*;
#(
   parameter int N      = LANES_D,
   parameter int ENT_W  = ENT_W_D,
   parameter int COS_W  = COS_W_D,
   parameter int SUM_W  = SUM_W_D,
   parameter int QIN_W  = QIN_W_D,
   parameter int IQ_W   = IQ_W_D,
   parameter int OUT_W  = COEF_W_D,
   parameter bit ROUND  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ld_en,
   input  logic [$clog2(N)-1:0]   ld_sel,
   input  logic [ENT_W-1:0]       ld_val,
   input  logic                   go,
   input  logic [N*COS_W-1:0]     cos_row,
   input  logic [IQ_W-1:0]        iq_val,
   output logic                   coef_valid,
   output logic [OUT_W-1:0]       coef
);

   localparam int SEL_W = $clog2(N);

   logic [N-1:0][ENT_W-1:0] ent;
   logic                    sum_v;
   logic [SUM_W-1:0]        sum;
   logic [IQ_W-1:0]         iq_d;

   colq_bank #(.N(N), .ENT_W(ENT_W), .SEL_W(SEL_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ld_en),
      .wr_sel  (ld_sel),
      .wr_data (ld_val),
      .ent     (ent)
   );

   colq_mac #(.N(N), .ENT_W(ENT_W), .COS_W(COS_W), .SUM_W(SUM_W), .IQ_W(IQ_W)) u_mac (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_v    (go),
      .ent     (ent),
      .cos_row (cos_row),
      .iq_in   (iq_val),
      .sum_v   (sum_v),
      .sum     (sum),
      .iq_out  (iq_d)
   );

   colq_quant #(.SUM_W(SUM_W), .QIN_W(QIN_W), .IQ_W(IQ_W), .OUT_W(OUT_W), .ROUND(ROUND)) u_quant (
      .clk   (clk),
      .rst_n (rst_n),
      .in_v  (sum_v),
      .sum   (sum),
      .iq    (iq_d),
      .out_v (coef_valid),
      .coef  (coef)
   );

   // R8: fixed three-edge issue-to-result delay
   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> ##3 coef_valid);

   // R1: bank cleared by reset
   p_reset_bank_r1: assert property (@(posedge clk)
      !rst_n |=> (ent == '0));

endmodule

// File: tb/colq_top_tb_top.sv
`timescale 1ns/1ps
module colq_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0;
   logic [2:0]  ld_sel = '0;
   logic [10:0] ld_val = '0;
   logic        go = 1'b0;
   logic [63:0] cos_row = '0;
   logic [7:0]  iq_val = '0;
   logic        coef_valid;
   logic [8:0]  coef;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int bank_m [8];
   int exp_q [$];
   int cyc_q [$];
   int last_coef = 0;
   bit mon_on = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   colq_top dut_i (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
      .go(go), .cos_row(cos_row), .iq_val(iq_val),
      .coef_valid(coef_valid), .coef(coef)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // integer reference of R5..R7
   function automatic int ref_coef(input logic [63:0] cr, input int q);
      int s, v, p;
      s = 0;
      for (int i = 0; i < 8; i++)
         s += bank_m[i] * int'($signed(cr[8*i +: 8]));
      v = s & 32'hFFF;
      if (v >= 2048) v -= 4096;
      p = v * q;
      return (p + 1024) >>> 11;
   endfunction

   // driver: one cycle of stimulus, pushes the expected result on issue
   task automatic step(input bit we, input int sel, input int dat,
                       input bit g, input logic [63:0] cr, input int q);
      @(negedge clk);
      ld_en = we; ld_sel = sel[2:0]; ld_val = dat[10:0];
      go = g; cos_row = cr; iq_val = q[7:0];
      if (g) begin
         exp_q.push_back(ref_coef(cr, q & 255));
         cyc_q.push_back(cyc);
      end
      if (we) bank_m[sel & 7] = int'($signed(dat[10:0]));
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, 64'd0, 0);
   endtask

   function automatic logic [63:0] unit_row(input int lane, input int val);
      logic [63:0] r;
      r = '0;
      r[8*lane +: 8] = val[7:0];
      return r;
   endfunction

   // monitor / scoreboard
   always @(negedge clk) begin
      if (mon_on && rst_n) begin
         if (coef_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 unexpected result", int'($signed(coef)), 0);
            end else begin
               int e, c0;
               e  = exp_q.pop_front();
               c0 = cyc_q.pop_front();
               chk(int'($signed(coef)) == e, "R5/R6/R7 coefficient", int'($signed(coef)), e);
               chk((cyc - c0) == 3, "R8 latency", cyc - c0, 3);
            end
            last_coef = int'($signed(coef));
         end else begin
            chk(int'($signed(coef)) == last_coef, "R9 hold", int'($signed(coef)), last_coef);
         end
      end
   end

   // watchdog
   initial begin
      #(8 * 150000);
      bad++; total++;
      $display("FAIL R8 watchdog: cycles=%0d expected below %0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) bank_m[i] = 0;
      repeat (3) @(negedge clk);
      // R1: state under reset
      chk(coef_valid == 1'b0, "R1 valid in reset", int'(coef_valid), 0);
      chk(coef == 9'd0, "R1 coef in reset", int'(coef), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(coef_valid == 1'b0, "R1 valid after release", int'(coef_valid), 0);
      mon_on = 1'b1;

      // R1: cleared bank gives zero for any row
      step(0, 0, 0, 1, 64'h7F80_11EE_4433_2211, 200);
      idle(4);

      // R2: load all slots, walk unit rows over lanes
      for (int i = 0; i < 8; i++) step(1, i, 130 * i - 500, 0, 64'd0, 0);
      for (int i = 0; i < 8; i++) step(0, 0, 0, 1, unit_row(i, 64), 128);
      idle(4);

      // R3: strobe low, data must be ignored
      step(0, 2, 1023, 0, 64'd0, 0);
      step(0, 5, -1024, 0, 64'd0, 0);
      step(0, 0, 0, 1, unit_row(2, 100), 255);
      step(0, 0, 0, 1, unit_row(5, 100), 255);
      idle(4);

      // R2: single write leaves the others
      step(1, 5, 77, 0, 64'd0, 0);
      step(0, 0, 0, 1, {8{8'h01}}, 200);
      idle(4);

      // R5: wrap of large sums
      for (int i = 0; i < 8; i++) step(1, i, -1024, 0, 64'd0, 0);
      step(0, 0, 0, 1, {8{8'h80}}, 255);
      for (int i = 0; i < 8; i++) step(1, i, 1023, 0, 64'd0, 0);
      step(0, 0, 0, 1, {8{8'h7F}}, 255);
      step(0, 0, 0, 1, {8{8'h81}}, 255);
      idle(4);

      // R7: rounding at the half-LSB boundary; R6: zero and unit steps
      for (int i = 0; i < 8; i++) step(1, i, 0, 0, 64'd0, 0);
      step(1, 0, 512, 0, 64'd0, 0);
      step(0, 0, 0, 1, unit_row(0, 2), 1);
      step(0, 0, 0, 1, unit_row(0, -2), 1);
      step(0, 0, 0, 1, unit_row(0, 3), 1);
      step(0, 0, 0, 1, unit_row(0, 3), 0);
      step(0, 0, 0, 1, unit_row(0, 3), 255);
      idle(4);

      // R4/R8: back-to-back issues overlapping writes
      for (int i = 0; i < 8; i++)
         step(1, (i + 3) & 7, 40 * i - 150, 1, {8{8'(i * 17 - 60)}}, 30 + 25 * i);
      for (int i = 0; i < 8; i++)
         step(0, 0, 0, 1, unit_row(i, -128 + i), 255 - i);
      idle(4);

      // random mix
      for (int n = 0; n < 400; n++) begin
         step($urandom_range(0, 2) == 0, $urandom_range(0, 7), $urandom_range(0, 2047),
              $urandom_range(0, 1) == 1, {$urandom, $urandom}, $urandom_range(0, 255));
      end
      idle(6);

      chk(exp_q.size() == 0, "R8 drained", exp_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule